// File: doc/BRIEF.md
# Double-Buffered Dual-Link Result Unloader

This block is the output stage for a linear row of M processing elements, with M = floor(N/2)+1 for an N-point transform. Element e holds two results. Under the default routing, the first result is point e and the second is point N-e. A one-cycle capture pulse copies every element's routed results into a private pair of shift chains, one chain per serial link. The chains then drain one position per cycle. Meanwhile the element row is free to compute the next set of results, so unloading overlaps with computation.

Each link has one routing bit per element. The bit chooses which of the element's two results fills that link's chain position. The chains drain toward opposite ends. Link 0 presents element 0 first and walks upward. Link 1 presents element M-1 first and walks downward. With the default routing, both links therefore deliver their points in ascending index order.

Every unload phase lasts exactly N cycles. A per-link valid strobe marks only the required points:
- The redundant mirror point (index N) held by element 0 is never marked valid.
- For even N, the duplicated middle point is marked valid only once.

A capture that arrives during a phase is remembered. It starts the next phase with no idle cycle in between.

Top module: `outchain_top`

## Requirements
- R1: After reset, both valid strobes stay low and no phase runs until the first capture pulse.
- R2: A capture pulse while idle loads all shadow positions at that clock edge. On the following cycle, link 0 presents element 0's routed result. It then presents elements 1 to M-1, one per cycle.
- R3: On the cycle after a load, link 1 presents element M-1's routed result. It then presents elements M-2 down to 0, one per cycle.
- R4: Each element has one routing bit per link. A bit value of 0 selects the element's first result and a value of 1 selects its second result. The bits are sampled at the loading edge.
- R5: The second result of element 0 is never flagged valid on either link.
- R6: For even N, the second result of element M-1 is never flagged valid. For odd N, it is flagged valid like any other slot.
- R7: A phase lasts exactly N cycles. Slots M to N-1 of a phase carry a low valid on both links. Without a pending capture, the block is idle afterwards.
- R8: A capture pulse during a phase, other than in its last cycle, is held. A pulse in the last cycle is taken directly. In both cases, the next load happens at the edge that ends the current phase, using the results present at that edge. The new slot 0 appears on the next cycle.
- R9: Changing the results or the routing bits after the loading edge does not affect the phase in progress.
- R10: With link 0 routed to first results and link 1 routed to second results, link 0 delivers points 0 to floor(N/2) in ascending order. Link 1 delivers points floor(N/2)+1 to N-1 in ascending order. The phase carries exactly N valid slots in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_i | input | 1 | Capture pulse |
| res_first_i | input | M*W | First result of each element, element e at bits [e*W +: W] |
| res_second_i | input | M*W | Second result of each element, same packing |
| route0_i | input | M | Link 0 routing bit per element (0 = first, 1 = second) |
| route1_i | input | M | Link 1 routing bit per element (0 = first, 1 = second) |
| ser0_data_o | output | W | Link 0 serial data |
| ser0_vld_o | output | 1 | Link 0 valid strobe |
| ser1_data_o | output | W | Link 1 serial data |
| ser1_vld_o | output | 1 | Link 1 valid strobe |

## Verification
The assertions watch the following on every cycle:
- the phase counter ending the phase after exactly N cycles;
- a mid-phase capture setting the pending flag, and that flag forcing a reload at the phase boundary;
- an idle capture loading at once;
- the first slot after any load showing the correctly routed element data, with the drop rules for element 0 and the last element applied.

Only the bench scenarios can show the remaining behaviour:
- the complete slot-by-slot ordering on both links under several routing patterns;
- the exact count of valid points;
- immunity to input changes during a phase;
- the gap-free start of a queued phase;
- the odd-N case, where the last element's second result stays valid.

// File: rtl/outchain_pkg.sv
package outchain_pkg;

    typedef enum logic {
        UNLOAD_ASC  = 1'b0,
        UNLOAD_DESC = 1'b1
    } unload_dir_e;

    function automatic int elem_count(input int npts);
        return npts / 2 + 1;
    endfunction

endpackage

// File: rtl/outchain_route_slot.sv
module outchain_route_slot #(
    parameter int W    = 16,
    parameter int IDX  = 0,
    parameter int M    = 5,
    parameter bit EVEN = 1'b1
) (
    input  logic [W-1:0] first_i,
    input  logic [W-1:0] second_i,
    input  logic         sel_i,
    output logic [W-1:0] data_o,
    output logic         keep_o
);
    // the second result is redundant at element 0, and at the last element for even sizes
    localparam bit SECOND_REDUNDANT = (IDX == 0) || (EVEN && (IDX == M - 1));

    always_comb begin
        data_o = sel_i ? second_i : first_i;
        keep_o = !(sel_i && SECOND_REDUNDANT);
    end

endmodule

// File: rtl/outchain_chain.sv
module outchain_chain
    import outchain_pkg::*;
#(
    parameter int          W   = 16,
    parameter int          M   = 5,
    parameter unload_dir_e DIR = UNLOAD_ASC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               shift_i,
    input  logic [M-1:0][W-1:0] load_data_i,
    input  logic [M-1:0]       load_keep_i,
    output logic [W-1:0]       head_data_o,
    output logic               head_keep_o
);
    typedef struct packed {
        logic [M-1:0][W-1:0] data;
        logic [M-1:0]        keep;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.data = load_data_i;
            st_d.keep = load_keep_i;
        end else if (shift_i) begin
            if (DIR == UNLOAD_ASC) begin
                st_d.data = {{W{1'b0}}, st_q.data[M-1:1]};
                st_d.keep = {1'b0, st_q.keep[M-1:1]};
            end else begin
                st_d.data = {st_q.data[M-2:0], {W{1'b0}}};
                st_d.keep = {st_q.keep[M-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (DIR == UNLOAD_ASC) begin : g_head_low
            assign head_data_o = st_q.data[0];
            assign head_keep_o = st_q.keep[0];
        end else begin : g_head_high
            assign head_data_o = st_q.data[M-1];
            assign head_keep_o = st_q.keep[M-1];
        end
    endgenerate

endmodule

// File: rtl/outchain_phase_ctrl.sv
module outchain_phase_ctrl #(
    parameter int NPTS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_i,
    output logic load_o,
    output logic shift_o,
    output logic active_o
);
    localparam int CW = (NPTS > 1) ? $clog2(NPTS) : 1;
    localparam logic [CW-1:0] LAST = CW'(NPTS - 1);

    typedef struct packed {
        logic          active;
        logic          pend;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  at_last;

    always_comb begin
        st_d    = st_q;
        load_o  = 1'b0;
        at_last = st_q.active && (st_q.cnt == LAST);
        if (!st_q.active) begin
            if (cap_i) begin
                load_o      = 1'b1;
                st_d.active = 1'b1;
                st_d.cnt    = '0;
            end
        end else if (at_last) begin
            st_d.pend = 1'b0;
            st_d.cnt  = '0;
            if (cap_i || st_q.pend) load_o = 1'b1;
            else                    st_d.active = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (cap_i) st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shift_o  = st_q.active;
    assign active_o = st_q.active;

    // R7
    phase_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.cnt == LAST && !st_q.pend && !cap_i) |=> !st_q.active);

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.cnt != LAST && cap_i) |=> (st_q.pend && st_q.active));

    // R8
    pend_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.cnt == LAST && st_q.pend) |=> (st_q.active && st_q.cnt == '0 && !st_q.pend));

    // R2
    idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && cap_i) |=> (st_q.active && st_q.cnt == '0));

endmodule

// File: rtl/outchain_top.sv
module outchain_top
    import outchain_pkg::*;
#(
    parameter int NPTS = 8,
    parameter int W    = 16,
    localparam int M   = elem_count(NPTS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cap_i,
    input  logic [M*W-1:0] res_first_i,
    input  logic [M*W-1:0] res_second_i,
    input  logic [M-1:0]   route0_i,
    input  logic [M-1:0]   route1_i,
    output logic [W-1:0]   ser0_data_o,
    output logic           ser0_vld_o,
    output logic [W-1:0]   ser1_data_o,
    output logic           ser1_vld_o
);
    localparam bit EVEN = (NPTS % 2) == 0;

    logic                      load, shift, active;
    logic [1:0][M-1:0]         route_all;
    logic [1:0][M-1:0][W-1:0]  slot_data;
    logic [1:0][M-1:0]         slot_keep;
    logic [1:0][W-1:0]         head_data;
    logic [1:0]                head_keep;

    assign route_all = {route1_i, route0_i};

    outchain_phase_ctrl #(.NPTS(NPTS)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   (cap_i),
        .load_o  (load),
        .shift_o (shift),
        .active_o(active)
    );

    generate
        for (genvar l = 0; l < 2; l++) begin : g_link
            for (genvar e = 0; e < M; e++) begin : g_elem
                outchain_route_slot #(.W(W), .IDX(e), .M(M), .EVEN(EVEN)) u_slot (
                    .first_i (res_first_i[e*W +: W]),
                    .second_i(res_second_i[e*W +: W]),
                    .sel_i   (route_all[l][e]),
                    .data_o  (slot_data[l][e]),
                    .keep_o  (slot_keep[l][e])
                );
            end
            outchain_chain #(
                .W(W), .M(M),
                .DIR((l == 0) ? UNLOAD_ASC : UNLOAD_DESC)
            ) u_chain (
                .clk        (clk),
                .rst_n      (rst_n),
                .load_i     (load),
                .shift_i    (shift),
                .load_data_i(slot_data[l]),
                .load_keep_i(slot_keep[l]),
                .head_data_o(head_data[l]),
                .head_keep_o(head_keep[l])
            );
        end
    endgenerate

    assign ser0_data_o = head_data[0];
    assign ser1_data_o = head_data[1];
    assign ser0_vld_o  = active && head_keep[0];
    assign ser1_vld_o  = active && head_keep[1];

    // R2
    first_slot_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) |-> (ser0_data_o == ($past(route0_i[0]) ? $past(res_second_i[W-1:0])
                                                            : $past(res_first_i[W-1:0]))));

    // R5
    elem0_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(load) && $past(route0_i[0])) |-> !ser0_vld_o);

    generate
        if (EVEN) begin : g_even_chk
            // R6
            mid_dup_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(load) && $past(route1_i[M-1])) |-> !ser1_vld_o);
        end else begin : g_odd_chk
            // R6
            last_second_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(load) && $past(route1_i[M-1])) |-> ser1_vld_o);
        end
    endgenerate

endmodule

// File: tb/tb_outchain_top.sv
module tb_outchain_top;
    localparam int W  = 16;
    localparam int N8 = 8;
    localparam int M8 = 5;
    localparam int N7 = 7;
    localparam int M7 = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic            cap8 = 1'b0, cap7 = 1'b0;
    logic [M8*W-1:0] f8 = '0, s8 = '0;
    logic [M8-1:0]   r08 = '0, r18 = '0;
    logic [M7*W-1:0] f7 = '0, s7 = '0;
    logic [M7-1:0]   r07 = '0, r17 = '0;
    logic [W-1:0]    d08, d18, d07, d17;
    logic            v08, v18, v07, v17;

    outchain_top #(.NPTS(N8), .W(W)) dut (
        .clk(clk), .rst_n(rst_n), .cap_i(cap8),
        .res_first_i(f8), .res_second_i(s8), .route0_i(r08), .route1_i(r18),
        .ser0_data_o(d08), .ser0_vld_o(v08), .ser1_data_o(d18), .ser1_vld_o(v18));

    outchain_top #(.NPTS(N7), .W(W)) dut_odd (
        .clk(clk), .rst_n(rst_n), .cap_i(cap7),
        .res_first_i(f7), .res_second_i(s7), .route0_i(r07), .route1_i(r17),
        .ser0_data_o(d07), .ser0_vld_o(v07), .ser1_data_o(d17), .ser1_vld_o(v17));

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    function automatic logic [W-1:0] dval(input int base, input logic second, input int e);
        return W'(base + (second ? 16'h0200 : 16'h0100) + e);
    endfunction

    task automatic set8(input int base);
        for (int e = 0; e < M8; e++) begin
            f8[e*W +: W] = dval(base, 1'b0, e);
            s8[e*W +: W] = dval(base, 1'b1, e);
        end
    endtask

    task automatic set7(input int base);
        for (int e = 0; e < M7; e++) begin
            f7[e*W +: W] = dval(base, 1'b0, e);
            s7[e*W +: W] = dval(base, 1'b1, e);
        end
    endtask

    // called at a negedge; returns at the negedge where slot 0 is visible
    task automatic pulse8();
        cap8 = 1'b1;
        @(negedge clk);
        cap8 = 1'b0;
    endtask

    // checks all n slots of a phase; returns at the negedge after the phase
    task automatic check_run(input string rq, input int n, input int m, input bit even,
                             input logic [4:0] sel0, input logic [4:0] sel1,
                             input int base, input bit odd_dut);
        for (int k = 0; k < n; k++) begin
            for (int l = 0; l < 2; l++) begin
                int e;
                logic sel;
                logic ev, av;
                logic [W-1:0] ed, ad;
                e  = (l == 0) ? k : m - 1 - k;
                ev = 1'b0;
                ed = '0;
                if (k < m) begin
                    sel = (l == 0) ? sel0[e] : sel1[e];
                    ev  = !(sel && (e == 0 || (even && e == m - 1)));
                    ed  = dval(base, sel, e);
                end
                if (odd_dut) begin av = (l == 0) ? v07 : v17; ad = (l == 0) ? d07 : d17; end
                else         begin av = (l == 0) ? v08 : v18; ad = (l == 0) ? d08 : d18; end
                checks++;
                if (av !== ev) begin
                    fails++;
                    $display("FAIL %s link%0d slot %0d valid act=%0b exp=%0b", rq, l, k, av, ev);
                end
                if (ev && av === 1'b1) begin
                    checks++;
                    if (ad !== ed) begin
                        fails++;
                        $display("FAIL %s link%0d slot %0d data act=%h exp=%h", rq, l, k, ad, ed);
                    end
                end
            end
            @(negedge clk);
        end
    endtask

    task automatic check_idle(input string rq);
        checks++;
        if (v08 !== 1'b0 || v18 !== 1'b0) begin
            fails++;
            $display("FAIL %s idle valid act=%0b%0b exp=00", rq, v08, v18);
        end
    endtask

    // R1
    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            check_idle("R1");
            @(negedge clk);
        end
    endtask

    // R2 R3 R5 R6 R10: default routing, ordered output
    task automatic t_default();
        r08 = '0; r18 = '1; set8(16'h1000);
        pulse8();
        check_run("R2/R3/R10", N8, M8, 1'b1, 5'b00000, 5'b11111, 16'h1000, 1'b0);
        check_idle("R7");
        repeat (2) @(negedge clk);
        check_idle("R7");
    endtask

    // R4 R5 R6: swapped and mixed routing
    task automatic t_routing();
        r08 = '1; r18 = '0; set8(16'h2000);
        pulse8();
        check_run("R4/R5", N8, M8, 1'b1, 5'b11111, 5'b00000, 16'h2000, 1'b0);
        r08 = 5'b10110; r18 = 5'b01001; set8(16'h3000);
        pulse8();
        check_run("R4/R6", N8, M8, 1'b1, 5'b10110, 5'b01001, 16'h3000, 1'b0);
    endtask

    // R9: inputs change every cycle during the phase
    task automatic t_stable();
        r08 = 5'b00101; r18 = 5'b11010; set8(16'h4000);
        pulse8();
        fork
            check_run("R9", N8, M8, 1'b1, 5'b00101, 5'b11010, 16'h4000, 1'b0);
            for (int i = 0; i < N8; i++) begin
                set8(16'h7000 + i * 16'h0010);
                r08 = ~r08; r18 = ~r18;
                @(negedge clk);
            end
        join
    endtask

    // R8: capture mid-phase is queued, next phase follows without a gap
    task automatic t_pending();
        r08 = '0; r18 = '1; set8(16'h5000);
        pulse8();
        fork
            check_run("R8", N8, M8, 1'b1, 5'b00000, 5'b11111, 16'h5000, 1'b0);
            begin
                repeat (3) @(negedge clk);
                cap8 = 1'b1;
                set8(16'h6000);
                @(negedge clk);
                cap8 = 1'b0;
            end
        join
        check_run("R8", N8, M8, 1'b1, 5'b00000, 5'b11111, 16'h6000, 1'b0);
        check_idle("R7");
    endtask

    // R6 odd size: second result of last element kept
    task automatic t_odd();
        r07 = '0; r17 = '1; set7(16'h0800);
        cap7 = 1'b1;
        @(negedge clk);
        cap7 = 1'b0;
        check_run("R6/R10 odd", N7, M7, 1'b0, 5'b00000, 5'b01111, 16'h0800, 1'b1);
        checks++;
        if (v07 !== 1'b0 || v17 !== 1'b0) begin
            fails++;
            $display("FAIL R7 odd idle valid act=%0b%0b exp=00", v07, v17);
        end
    endtask

    initial begin
        t_reset();
        t_default();
        t_routing();
        t_stable();
        t_pending();
        t_odd();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule